// File: doc/BRIEF.md
# Three-Channel Priority Word-Copy Controller

This block copies runs of 32-bit words from one memory region to another on behalf of software. It has three channels, each with its own register bank, and they share one memory port. A channel is loaded through a word-addressed register port and then started by setting the start bit in its enable register. Channel 0 always outranks channel 1, and channel 1 outranks channel 2. The arbiter decides again after every word, so a channel that starts later but ranks higher suspends a lower one at a word boundary. The lower channel resumes once the higher channel has finished.

Each channel can run in one of two modes. In direct mode it takes the source address, destination address and byte count from its own registers. In chained mode its destination register instead points to a list of descriptors held in memory. Each descriptor is three words: byte count, destination, source. Bit 31 of the source word marks the last descriptor. A shared engine runs the transfers. Its states are IDLE (arbitrate and pick the winning channel), DRD (issue a descriptor word read), DCAP (capture that word into the channel), RD (issue the source word read) and WR (write the returned word and step the addresses). Its transitions are as follows:
- IDLE goes to DRD when the winning channel needs a descriptor, and to RD otherwise.
- DRD always goes to DCAP.
- DCAP goes back to DRD until the third descriptor word has been captured, then goes to IDLE.
- RD always goes to WR.
- WR always goes to IDLE.

Top module: `dma3_ctrl`

## Requirements
- R1: After reset, every register reads 0, including the status word at word address 24 (busy in bits 2:0, end flags in bits 6:4, illegal flags in bits 10:8, bit n for channel n).
- R2: A direct transfer of byte count C moves C/4 words. Word i is read from the source address plus 4*i. Register word address = channel*8 + offset, with offsets: source 0, destination 1, count 2, step 3, enable 4, mode 5.
- R3: The destination address advances by 2^S bytes per word, where S is bits 2:0 of the step register.
- R4: Channel 0 outranks 1, and 1 outranks 2. A higher channel that starts while a lower one is running finishes first, and the lower one then completes with correct data.
- R5: A byte count below 4 is illegal, and so is a count at or above the channel's limit (1 MiB for channel 0, 4 KiB for channels 1 and 2). An illegal count sets the channel's illegal flag, moves no data and leaves the channel idle.
- R6: When mode bit 24 is 1, the channel walks descriptors starting at its destination register. Each descriptor is three words: count, destination, source. Bits 30:0 of the source word give the source address, and bit 31 marks the last descriptor.
- R7: Writes to the registers of a busy channel are ignored.
- R8: Channel 2 does not move any data while channel 1 is busy; a start on channel 2 stays pending until then.
- R9: The end flag is set when a transfer completes and stays set. Writing 1 to its status bit clears it, and clears the illegal flag the same way.
- R10: In direct mode, mode bit 16 makes the source register hold the final source address after the end, and mode bit 8 does the same for the destination register.
- R11: Writing 1 to bit 8 of the enable register starts an idle channel. While the channel runs, bit 8 of the enable register reads 1 and so does its busy bit in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |

## Verification
The hardest case to reach from the ports is a lower channel being suspended in the middle of a run and then resumed. To get there, the stimulus starts a long transfer on channel 2, waits a fixed number of cycles, and then loads and starts channel 0. It checks that channel 0 ends while channel 2 is still busy, and that both destination images are correct afterwards. The bench also checks the channel 1 / channel 2 hold-off. It samples the moment channel 1's end flag appears and confirms that channel 2's first destination word has not yet been written.

// File: rtl/dma3_pkg.sv
package dma3_pkg;
    localparam int NCH = 3;
    localparam int DW  = 32;

    typedef enum logic [2:0] {
        E_IDLE,
        E_DRD,
        E_DCAP,
        E_RD,
        E_WR
    } eng_state_t;

    localparam logic [2:0] OFF_SRC  = 3'd0;
    localparam logic [2:0] OFF_DST  = 3'd1;
    localparam logic [2:0] OFF_CNT  = 3'd2;
    localparam logic [2:0] OFF_STEP = 3'd3;
    localparam logic [2:0] OFF_EN   = 3'd4;
    localparam logic [2:0] OFF_MODE = 3'd5;

    localparam int START_BIT = 8;
    localparam int CHAIN_BIT = 24;
    localparam int RUPD_BIT  = 16;
    localparam int WUPD_BIT  = 8;
    localparam int LAST_BIT  = 31;
endpackage

// File: rtl/dma3_chan.sv
module dma3_chan
    import dma3_pkg::*;
#(
    parameter int unsigned LIMIT = 32'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_off,
    output logic [DW-1:0] rd_data,
    input  logic          clr_end,
    input  logic          clr_ill,
    input  logic          desc_vld,
    input  logic [1:0]    desc_idx,
    input  logic [DW-1:0] desc_data,
    input  logic          step,
    output logic          busy,
    output logic          end_f,
    output logic          ill_f,
    output logic          need_desc,
    output logic [DW-1:0] cur_src,
    output logic [DW-1:0] cur_dst,
    output logic [DW-1:0] tbl_ptr
);
    localparam int CW = $clog2(LIMIT);

    logic [DW-1:0] r_src, r_dst, r_cnt, r_step, r_mode;
    logic [DW-1:0] d_cnt;
    logic [CW-1:0] left;
    logic          last_seg;
    logic          start;
    logic          chain;
    logic [DW-1:0] stride;

    function automatic logic count_ok(input logic [DW-1:0] c);
        return (c < DW'(LIMIT)) && (c[DW-1:2] != '0);
    endfunction

    assign chain  = r_mode[CHAIN_BIT];
    assign stride = DW'(1) << r_step[2:0];
    assign start  = wr_en && (wr_off == OFF_EN) && wr_data[START_BIT] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_src <= '0; r_dst <= '0; r_cnt <= '0; r_step <= '0; r_mode <= '0;
            d_cnt <= '0; left <= '0; last_seg <= 1'b0;
            busy <= 1'b0; end_f <= 1'b0; ill_f <= 1'b0; need_desc <= 1'b0;
            cur_src <= '0; cur_dst <= '0; tbl_ptr <= '0;
        end else begin
            if (clr_end) end_f <= 1'b0;
            if (clr_ill) ill_f <= 1'b0;
            if (wr_en && !busy) begin
                unique case (wr_off)
                    OFF_SRC:  r_src  <= wr_data;
                    OFF_DST:  r_dst  <= wr_data;
                    OFF_CNT:  r_cnt  <= wr_data;
                    OFF_STEP: r_step <= wr_data;
                    OFF_MODE: r_mode <= wr_data;
                    default:  ;
                endcase
            end
            if (start) begin
                if (chain) begin
                    busy      <= 1'b1;
                    need_desc <= 1'b1;
                    tbl_ptr   <= r_dst;
                    last_seg  <= 1'b0;
                end else if (count_ok(r_cnt)) begin
                    busy      <= 1'b1;
                    need_desc <= 1'b0;
                    cur_src   <= r_src;
                    cur_dst   <= r_dst;
                    left      <= {2'b00, r_cnt[CW-1:2]};
                end else begin
                    ill_f <= 1'b1;
                end
            end
            if (desc_vld) begin
                unique case (desc_idx)
                    2'd0: d_cnt   <= desc_data;
                    2'd1: cur_dst <= desc_data;
                    default: begin
                        cur_src   <= {1'b0, desc_data[LAST_BIT-1:0]};
                        last_seg  <= desc_data[LAST_BIT];
                        tbl_ptr   <= tbl_ptr + DW'(12);
                        need_desc <= 1'b0;
                        if (count_ok(d_cnt)) begin
                            left <= {2'b00, d_cnt[CW-1:2]};
                        end else begin
                            ill_f <= 1'b1;
                            busy  <= 1'b0;
                        end
                    end
                endcase
            end
            if (step) begin
                cur_src <= cur_src + DW'(4);
                cur_dst <= cur_dst + stride;
                left    <= left - CW'(1);
                if (left == CW'(1)) begin
                    if (chain && !last_seg) begin
                        need_desc <= 1'b1;
                    end else begin
                        busy  <= 1'b0;
                        end_f <= 1'b1;
                        if (!chain && r_mode[RUPD_BIT]) r_src <= cur_src + DW'(4);
                        if (!chain && r_mode[WUPD_BIT]) r_dst <= cur_dst + stride;
                    end
                end
            end
        end
    end

    always_comb begin
        unique case (rd_off)
            OFF_SRC:  rd_data = r_src;
            OFF_DST:  rd_data = r_dst;
            OFF_CNT:  rd_data = r_cnt;
            OFF_STEP: rd_data = r_step;
            OFF_EN:   rd_data = DW'(busy) << START_BIT;
            OFF_MODE: rd_data = r_mode;
            default:  rd_data = '0;
        endcase
    end

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && wr_off == OFF_SRC) |=> (r_src == $past(r_src)));

    p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_f) |-> !busy);

    p_dst_stride_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_dst == $past(cur_dst) + (DW'(1) << $past(r_step[2:0]))));
endmodule

// File: rtl/dma3_arb.sv
module dma3_arb
    import dma3_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] busy,
    output logic [NCH-1:0] grant
);
    logic [NCH-1:0] req_m;
    logic [NCH:0]   taken;

    always_comb begin
        req_m    = req;
        req_m[2] = req[2] && !busy[1];
    end

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < NCH; i++) begin : g_prio
        assign grant[i]   = req_m[i] && !taken[i];
        assign taken[i+1] = taken[i] || req_m[i];
    end

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_ch2_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant[2] |-> !busy[1]);
endmodule

// File: rtl/dma3_engine.sv
module dma3_engine
    import dma3_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          grant,
    input  logic [NCH-1:0]          need_desc,
    input  logic [NCH-1:0][DW-1:0]  src_v,
    input  logic [NCH-1:0][DW-1:0]  dst_v,
    input  logic [NCH-1:0][DW-1:0]  tbl_v,
    output logic [NCH-1:0]          desc_vld,
    output logic [1:0]              desc_idx,
    output logic [DW-1:0]           desc_data,
    output logic [NCH-1:0]          step,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [DW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata
);
    localparam int SW = $clog2(NCH);

    eng_state_t state, nstate;
    logic [SW-1:0] cur, win;
    logic [1:0]    idx;

    always_comb begin
        win = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (grant[i]) win = SW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= E_IDLE;
            cur   <= '0;
            idx   <= '0;
        end else begin
            state <= nstate;
            if (state == E_IDLE && |grant) begin
                cur <= win;
                idx <= '0;
            end else if (state == E_DCAP) begin
                idx <= idx + 2'd1;
            end
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            E_IDLE: if (|grant) nstate = need_desc[win] ? E_DRD : E_RD;
            E_DRD:  nstate = E_DCAP;
            E_DCAP: nstate = (idx == 2'd2) ? E_IDLE : E_DRD;
            E_RD:   nstate = E_WR;
            E_WR:   nstate = E_IDLE;
            default: nstate = E_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        desc_vld  = '0;
        desc_idx  = idx;
        desc_data = mem_rdata;
        step      = '0;
        unique case (state)
            E_IDLE: ;
            E_DRD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_v[cur] + {28'd0, idx, 2'b00};
            end
            E_DCAP: desc_vld[cur] = 1'b1;
            E_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_v[cur];
            end
            E_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_v[cur];
                mem_wdata = mem_rdata;
                step[cur] = 1'b1;
            end
            default: ;
        endcase
    end

    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_req && !mem_we));

    p_step_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step));
endmodule

// File: rtl/dma3_ctrl.sv
module dma3_ctrl
    import dma3_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam logic [1:0] STAT_BANK = 2'd3;

    logic [NCH-1:0]         busy, end_f, ill_f, need_desc, grant, step, desc_vld;
    logic [NCH-1:0][DW-1:0] src_v, dst_v, tbl_v, chan_rd;
    logic [1:0]             desc_idx;
    logic [DW-1:0]          desc_data;
    logic                   stat_wr;

    assign stat_wr = reg_we && (reg_addr[4:3] == STAT_BANK) && (reg_addr[2:0] == 3'd0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int unsigned LIM = (i == 0) ? 32'h10_0000 : 32'h1000;
        dma3_chan #(.LIMIT(LIM)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we && (reg_addr[4:3] == 2'(i))),
            .wr_off    (reg_addr[2:0]),
            .wr_data   (reg_wdata),
            .rd_off    (reg_addr[2:0]),
            .rd_data   (chan_rd[i]),
            .clr_end   (stat_wr && reg_wdata[4+i]),
            .clr_ill   (stat_wr && reg_wdata[8+i]),
            .desc_vld  (desc_vld[i]),
            .desc_idx  (desc_idx),
            .desc_data (desc_data),
            .step      (step[i]),
            .busy      (busy[i]),
            .end_f     (end_f[i]),
            .ill_f     (ill_f[i]),
            .need_desc (need_desc[i]),
            .cur_src   (src_v[i]),
            .cur_dst   (dst_v[i]),
            .tbl_ptr   (tbl_v[i])
        );
    end

    dma3_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (busy),
        .busy  (busy),
        .grant (grant)
    );

    dma3_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .need_desc (need_desc),
        .src_v     (src_v),
        .dst_v     (dst_v),
        .tbl_v     (tbl_v),
        .desc_vld  (desc_vld),
        .desc_idx  (desc_idx),
        .desc_data (desc_data),
        .step      (step),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always_comb begin
        if (reg_addr[4:3] == STAT_BANK) begin
            reg_rdata = (reg_addr[2:0] == 3'd0)
                ? {21'd0, ill_f, 1'b0, end_f, 1'b0, busy} : '0;
        end else begin
            reg_rdata = chan_rd[reg_addr[4:3]];
        end
    end
endmodule

// File: tb/dma3_ctrl_tb.sv
module dma3_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int MW    = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [MW];
    logic [31:0] exp_mem [MW];
    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    dma3_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [4:0] ra(input int ch, input int off);
        return 5'(ch * 8 + off);
    endfunction

    task automatic load(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c, input logic [31:0] sh, input logic [31:0] md);
        wr(ra(ch, 0), s); wr(ra(ch, 1), d); wr(ra(ch, 2), c);
        wr(ra(ch, 3), sh); wr(ra(ch, 5), md);
    endtask

    task automatic go(input int ch);
        wr(ra(ch, 4), 32'h100);
    endtask

    task automatic model_copy(input logic [31:0] s, input logic [31:0] d,
                              input int words, input int sh);
        for (int i = 0; i < words; i++)
            exp_mem[(d + (i << sh)) >> 2 & 32'h3FF] = exp_mem[(s + 4 * i) >> 2 & 32'h3FF];
    endtask

    task automatic wait_end(input int ch, input string tag);
        logic [31:0] st;
        bit seen = 0;
        for (int n = 0; n < 4000 && !seen; n++) begin
            rd(5'd24, st);
            if (st[4 + ch]) seen = 1;
        end
        chk(seen, tag, 32'(seen), 32'd1);
    endtask

    task automatic compare_all(input string tag);
        int bad = -1;
        for (int i = MW - 1; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, mem[bad], exp_mem[bad]);
    endtask

    task automatic clear_all();
        wr(5'd24, 32'h770);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, st;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MW; i++) begin
            mem[i] = $urandom;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(5'd24, v); chk(v == 0, "R1 status after reset", v, 0);
        rd(ra(0, 0), v); chk(v == 0, "R1 ch0 source after reset", v, 0);
        rd(ra(1, 5), v); chk(v == 0, "R1 ch1 mode after reset", v, 0);

        // R2/R3: random direct transfers on all channels
        for (int t = 0; t < 8; t++) begin
            int ch = $urandom_range(0, 2);
            int n  = $urandom_range(1, 16);
            int sh = $urandom_range(2, 4);
            logic [31:0] s = 32'(4 * $urandom_range(0, 255));
            logic [31:0] d = 32'h800 + 32'(4 * $urandom_range(0, 64));
            load(ch, s, d, 32'(4 * n), 32'(sh), 32'h0);
            go(ch);
            model_copy(s, d, n, sh);
            wait_end(ch, "R2 direct end seen");
            compare_all($sformatf("R2 R3 direct copy ch%0d step%0d", ch, sh));
            clear_all();
        end

        // R9: end flag sticky and W1C
        load(1, 32'h40, 32'h900, 32'd8, 32'd2, 32'h0);
        go(1); model_copy(32'h40, 32'h900, 2, 2);
        wait_end(1, "R9 end seen");
        repeat (5) @(negedge clk);
        rd(5'd24, v); chk(v[5] == 1'b1, "R9 end sticky", v, 32'h20);
        wr(5'd24, 32'h20);
        rd(5'd24, v); chk(v == 0, "R9 end cleared by write-1", v, 0);

        // R5: illegal counts
        load(1, 32'h0, 32'hA00, 32'h1000, 32'd2, 32'h0); go(1);
        load(2, 32'h0, 32'hA00, 32'h1000, 32'd2, 32'h0); go(2);
        load(0, 32'h0, 32'hA00, 32'h0,    32'd2, 32'h0); go(0);
        repeat (4) @(negedge clk);
        rd(5'd24, v); chk(v == 32'h700, "R5 illegal flags, idle", v, 32'h700);
        compare_all("R5 no data moved");
        wr(5'd24, 32'h700);
        rd(5'd24, v); chk(v == 0, "R5 R9 illegal cleared", v, 0);
        load(0, 32'h0, 32'hA00, 32'h10_0000, 32'd2, 32'h0); go(0);
        repeat (3) @(negedge clk);
        rd(5'd24, v); chk(v == 32'h100, "R5 ch0 1MiB limit", v, 32'h100);
        clear_all();

        // R4/R7/R11: preemption of channel 2 by channel 0
        load(2, 32'h000, 32'h800, 32'd240, 32'd2, 32'h0);
        go(2); model_copy(32'h000, 32'h800, 60, 2);
        rd(ra(2, 4), v); chk(v == 32'h100, "R11 enable reads running", v, 32'h100);
        rd(5'd24, v); chk(v[2] == 1'b1, "R11 busy bit", v, 32'h4);
        wr(ra(2, 0), 32'h123);
        repeat (12) @(negedge clk);
        load(0, 32'h200, 32'hC00, 32'd32, 32'd3, 32'h0);
        go(0); model_copy(32'h200, 32'hC00, 8, 3);
        wait_end(0, "R4 ch0 end seen");
        rd(5'd24, v); chk(v[2] == 1'b1, "R4 ch2 still busy when ch0 ends", v, 32'h4);
        wait_end(2, "R4 ch2 end seen");
        compare_all("R4 both images correct");
        rd(ra(2, 0), v); chk(v == 0, "R7 write ignored while busy", v, 0);
        clear_all();

        // R8: channel 2 held while channel 1 runs
        load(1, 32'h100, 32'hA00, 32'd160, 32'd2, 32'h0);
        load(2, 32'h300, 32'hE80, 32'd16,  32'd2, 32'h0);
        go(1); go(2);
        model_copy(32'h100, 32'hA00, 40, 2);
        wait_end(1, "R8 ch1 end seen");
        chk(mem[32'hE80 >> 2] === exp_mem[32'hE80 >> 2], "R8 ch2 idle while ch1 ran",
            mem[32'hE80 >> 2], exp_mem[32'hE80 >> 2]);
        rd(5'd24, st); chk(st[2] == 1'b1, "R8 ch2 pending", st, 32'h4);
        model_copy(32'h300, 32'hE80, 4, 2);
        wait_end(2, "R8 ch2 end seen");
        compare_all("R8 images correct");
        clear_all();

        // R10: address update flags
        load(1, 32'h80, 32'hB00, 32'd20, 32'd3, 32'h0001_0100);
        go(1); model_copy(32'h80, 32'hB00, 5, 3);
        wait_end(1, "R10 end seen");
        rd(ra(1, 0), v); chk(v == 32'h94, "R10 source updated", v, 32'h94);
        rd(ra(1, 1), v); chk(v == 32'hB28, "R10 dest updated", v, 32'hB28);
        clear_all();

        // R6: chained descriptors
        mem[32'h600 >> 2] = 32'd20;  mem[32'h604 >> 2] = 32'hD00; mem[32'h608 >> 2] = 32'h100;
        mem[32'h60C >> 2] = 32'd12;  mem[32'h610 >> 2] = 32'hE00; mem[32'h614 >> 2] = 32'h8000_0200;
        for (int i = 0; i < 6; i++) exp_mem[(32'h600 >> 2) + i] = mem[(32'h600 >> 2) + i];
        load(2, 32'h0, 32'h600, 32'h0, 32'd2, 32'h0100_0000);
        go(2);
        model_copy(32'h100, 32'hD00, 5, 2);
        model_copy(32'h200, 32'hE00, 3, 2);
        wait_end(2, "R6 chain end seen");
        compare_all("R6 chained copy");
        rd(5'd24, v); chk(v == 32'h40, "R6 only ch2 end, idle", v, 32'h40);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule